// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital control for a 12-bit successive-approximation analog-to-digital converter. It drives a trial code to an external resistor-string DAC and a sample/hold control to the analog front end. Each cycle of the bit phase it reads back one comparator decision. It resolves the code one bit per cycle, from the most significant bit down. When the last bit is done, it latches the code into a result register and raises a one-cycle end-of-conversion interrupt.

A start flag controls conversions. In software mode, a write pulse sets the flag. In timer mode, a timer trigger pulse sets it by hardware. In single mode, the flag clears itself when the first conversion finishes. In continuous mode, sample-and-convert repeats until software clears the flag. Clearing the flag during a conversion aborts it.

A comparator-enable input gates everything. After it rises, a stabilization wait of a parameterized number of cycles must pass before any start is accepted.

Top module: `sar_adc_seq`

## Requirements
- R1: After reset, `result` is 0 and `start_flag`, `busy`, `sample_hold` and `eoc_irq` are all 0.
- R2: On the first cycle after the sample phase, `trial_code` is half scale, i.e. only bit NBITS-1 set (0x800 for 12 bits).
- R3: For each bit, the trial bit is kept at 1 when `comp_ge` is 1 (input >= trial level) and cleared when it is 0. With an ideal comparator, `result` therefore equals the held input code, including 0 and 4095.
- R4: `sample_hold` is high for exactly SAMPLE_CYC cycles at the start of each conversion. Changes to the input after the sample phase do not affect the result. `busy` is high for exactly SAMPLE_CYC+NBITS cycles, from the start of sampling until the result is latched.
- R5: `eoc_irq` is a single-cycle pulse, high in the first cycle in which the new `result` is visible. `result` changes at no other time.
- R6: With `trig_mode`=0, a `sw_start_set` pulse starts a conversion and `timer_trig` is ignored.
- R7: With `trig_mode`=1, a `timer_trig` pulse sets `start_flag` and starts a conversion, and `sw_start_set` is ignored.
- R8: With `cont_mode`=0, `start_flag` and `busy` are 0 in the cycle after the result latches, and no further conversion follows.
- R9: With `cont_mode`=1, a new sample phase starts in the cycle after each result latches, and conversions repeat until `sw_start_clr` is pulsed.
- R10: Start requests are ignored while `comp_en` is 0 and for SETTLE_CYC cycles after `comp_en` rises. Dropping `comp_en` aborts any conversion and clears `start_flag`.
- R11: A `sw_start_clr` pulse during a conversion makes `busy` and `start_flag` 0 on the next cycle. `result` keeps its previous value and no `eoc_irq` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| comp_en | input | 1 | Comparator enable; its rise starts the stabilization wait |
| trig_mode | input | 1 | 0 = software start, 1 = timer-trigger start |
| cont_mode | input | 1 | 0 = single conversion, 1 = continuous |
| sw_start_set | input | 1 | Software write pulse setting the start flag |
| sw_start_clr | input | 1 | Software write pulse clearing the start flag |
| timer_trig | input | 1 | Timer trigger pulse |
| comp_ge | input | 1 | Comparator: held input >= trial level |
| trial_code | output | NBITS | Trial code to the DAC |
| sample_hold | output | 1 | 1 = sample, 0 = hold |
| start_flag | output | 1 | Start/operation flag |
| busy | output | 1 | Sampling or converting |
| result | output | NBITS | Latched conversion result |
| eoc_irq | output | 1 | End-of-conversion interrupt pulse |

## Verification
The binary search is driven through an ideal comparator model with input codes at both rails, at the half-scale boundary (2047 versus 2048), and with alternating and one-hot patterns. These show whether every bit decision uses the >= rule and lands in the right position. One case changes the input after the sample phase, which separates correct holding from tracking. The trigger, mode, settle and abort cases use a known prior result so that any spurious latch or interrupt is visible.

// File: rtl/sar_adc_seq.sv
module sar_adc_seq #(
  parameter int NBITS      = 12,
  parameter int SETTLE_CYC = 20,
  parameter int SAMPLE_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             comp_en,
  input  logic             trig_mode,
  input  logic             cont_mode,
  input  logic             sw_start_set,
  input  logic             sw_start_clr,
  input  logic             timer_trig,
  input  logic             comp_ge,
  output logic [NBITS-1:0] trial_code,
  output logic             sample_hold,
  output logic             start_flag,
  output logic             busy,
  output logic [NBITS-1:0] result,
  output logic             eoc_irq
);
  localparam int SW = $clog2(SETTLE_CYC + 1);
  localparam int PW = (SAMPLE_CYC > 1) ? $clog2(SAMPLE_CYC) : 1;
  localparam int IW = $clog2(NBITS);
  localparam logic [SW-1:0]    SETTLE_MAX = SW'(SETTLE_CYC);
  localparam logic [PW-1:0]    SAMP_LAST  = PW'(SAMPLE_CYC - 1);
  localparam logic [IW-1:0]    TOP_IDX    = IW'(NBITS - 1);
  localparam logic [NBITS-1:0] HALF       = NBITS'(1) << (NBITS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SAMPLE, ST_CONV} st_t;

  st_t              state;
  logic [SW-1:0]    settle_cnt;
  logic [PW-1:0]    samp_cnt;
  logic [IW-1:0]    bit_idx;
  logic [NBITS-1:0] sar, sar_nxt;

  logic settled, abort, start_req, last_bit, conv_done;

  assign settled   = comp_en && (settle_cnt == SETTLE_MAX);
  assign abort     = sw_start_clr || !comp_en;
  assign start_req = settled && (trig_mode ? timer_trig : sw_start_set);
  assign last_bit  = (state == ST_CONV) && (bit_idx == '0);
  assign conv_done = last_bit && !abort;

  assign trial_code  = sar;
  assign sample_hold = (state == ST_SAMPLE);
  assign busy        = (state != ST_IDLE);

  always_comb begin
    sar_nxt = sar;
    sar_nxt[bit_idx] = comp_ge;
    if (bit_idx != '0) sar_nxt[bit_idx - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 settle_cnt <= '0;
    else if (!comp_en)          settle_cnt <= '0;
    else if (!settled)          settle_cnt <= settle_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          start_flag <= 1'b0;
    else if (abort)                      start_flag <= 1'b0;
    else if (conv_done && !cont_mode)    start_flag <= 1'b0;
    else if (start_req)                  start_flag <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      samp_cnt <= '0;
      bit_idx  <= '0;
      sar      <= '0;
      result   <= '0;
      eoc_irq  <= 1'b0;
    end else begin
      eoc_irq <= 1'b0;
      if (abort) begin
        state <= ST_IDLE;
      end else begin
        unique case (state)
          ST_IDLE: if (start_flag) begin
            state    <= ST_SAMPLE;
            samp_cnt <= '0;
            sar      <= '0;
          end
          ST_SAMPLE: if (samp_cnt == SAMP_LAST) begin
            state   <= ST_CONV;
            bit_idx <= TOP_IDX;
            sar     <= HALF;
          end else begin
            samp_cnt <= samp_cnt + 1'b1;
          end
          ST_CONV: begin
            sar <= sar_nxt;
            if (bit_idx != '0) begin
              bit_idx <= bit_idx - 1'b1;
            end else begin
              result   <= sar_nxt;
              eoc_irq  <= 1'b1;
              samp_cnt <= '0;
              state    <= cont_mode ? ST_SAMPLE : ST_IDLE;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R2
  msb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_hold && samp_cnt == SAMP_LAST && !abort) |=> (trial_code == HALF));

  // R4
  sample_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_hold |-> busy);

  // R5
  eoc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_irq |=> !eoc_irq);

  // R5
  result_only_on_eoc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> eoc_irq);

  // R8
  single_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_bit && !abort && !cont_mode) |=> (!start_flag && !busy));

  // R9
  cont_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_bit && !abort && cont_mode) |=> (sample_hold && start_flag));

  // R10
  no_start_unsettled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!settled && state == ST_IDLE) |=> (state == ST_IDLE));

  // R11
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_start_clr |=> (!busy && !eoc_irq && !start_flag));
endmodule

// File: tb/sar_adc_seq_tb_top.sv
module sar_adc_seq_tb_top;
  localparam int NB = 12, SETTLE = 20, SAMP = 4;

  logic clk = 0, rst_n = 0;
  logic comp_en = 0, trig_mode = 0, cont_mode = 0;
  logic sw_start_set = 0, sw_start_clr = 0, timer_trig = 0;
  logic comp_ge;
  logic [NB-1:0] trial_code, result;
  logic sample_hold, start_flag, busy, eoc_irq;

  int tests = 0, fails = 0;
  int vin = 0, held = 0;

  always #2 clk = ~clk;

  always @(posedge clk) if (sample_hold) held <= vin;
  assign comp_ge = (held >= int'(trial_code));

  sar_adc_seq #(.NBITS(NB), .SETTLE_CYC(SETTLE), .SAMPLE_CYC(SAMP)) dut_i (
    .clk, .rst_n, .comp_en, .trig_mode, .cont_mode, .sw_start_set, .sw_start_clr,
    .timer_trig, .comp_ge, .trial_code, .sample_hold, .start_flag, .busy, .result, .eoc_irq);

  localparam logic [23:0] VEC [8] = '{
    {12'd0,    12'd0},    {12'd4095, 12'd4095}, {12'd2048, 12'd2048}, {12'd2047, 12'd2047},
    {12'd1,    12'd1},    {12'hAAA,  12'hAAA},  {12'h555,  12'h555},  {12'h400,  12'h400}};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1; @(negedge clk); s = 0;
  endtask

  // waits for eoc; counts busy and sample cycles; optionally changes vin after sampling
  task automatic wait_eoc(input int late_v, output bit got, output int bcy, output int scy, output int first_trial);
    bit prev_s = 0;
    got = 0; bcy = 0; scy = 0; first_trial = -1;
    for (int i = 0; i < 200 && !got; i++) begin
      if (eoc_irq) got = 1;
      else begin
        if (busy) bcy++;
        if (sample_hold) scy++;
        if (prev_s && !sample_hold && busy && first_trial < 0) begin
          first_trial = int'(trial_code);
          if (late_v >= 0) vin = late_v;
        end
        prev_s = sample_hold;
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit got; int bcy, scy, ft, prev;
    repeat (3) @(negedge clk);
    // R1
    check(result == 0 && !start_flag && !busy && !sample_hold && !eoc_irq, "R1 reset", int'(result), 0);
    rst_n = 1;
    @(negedge clk);
    comp_en = 1;
    // R10: start too early
    repeat (5) @(negedge clk);
    pulse(sw_start_set);
    repeat (3) @(negedge clk);
    check(!start_flag && !busy, "R10 early start ignored", int'(busy), 0);
    repeat (SETTLE + 2) @(negedge clk);

    foreach (VEC[k]) begin
      vin = int'(VEC[k][23:12]);
      pulse(sw_start_set);
      wait_eoc(-1, got, bcy, scy, ft);
      check(got && result == VEC[k][11:0], "R3 result", int'(result), int'(VEC[k][11:0]));
      if (k == 0) begin
        check(ft == 2048, "R2 first trial", ft, 2048);
        check(scy == SAMP, "R4 sample cycles", scy, SAMP);
        check(bcy == SAMP + NB, "R4 busy cycles", bcy, SAMP + NB);
        @(negedge clk);
        check(!eoc_irq, "R5 eoc one cycle", int'(eoc_irq), 0);
        check(!start_flag && !busy, "R8 single stops", int'(start_flag), 0);
        repeat (20) @(negedge clk);
        check(!busy, "R8 no further conversion", int'(busy), 0);
      end
    end

    // R4 hold: input changes after sampling
    vin = 1000;
    pulse(sw_start_set);
    wait_eoc(3000, got, bcy, scy, ft);
    check(got && result == 1000, "R4 held input", int'(result), 1000);

    // R6 timer ignored in software mode
    pulse(timer_trig);
    repeat (3) @(negedge clk);
    check(!busy && !start_flag, "R6 timer ignored", int'(busy), 0);

    // R7 timer mode
    trig_mode = 1;
    pulse(sw_start_set);
    repeat (3) @(negedge clk);
    check(!busy && !start_flag, "R7 sw ignored", int'(busy), 0);
    vin = 777;
    pulse(timer_trig);
    check(start_flag, "R7 flag set by timer", int'(start_flag), 1);
    wait_eoc(-1, got, bcy, scy, ft);
    check(got && result == 777, "R7 timer conversion", int'(result), 777);
    trig_mode = 0;

    // R9 continuous
    cont_mode = 1;
    vin = 100;
    pulse(sw_start_set);
    wait_eoc(-1, got, bcy, scy, ft);
    check(got && result == 100, "R9 first result", int'(result), 100);
    vin = 3210;
    @(negedge clk);
    check(sample_hold && start_flag, "R9 resample", int'(sample_hold), 1);
    wait_eoc(-1, got, bcy, scy, ft);
    check(got && result == 3210, "R9 second result", int'(result), 3210);
    pulse(sw_start_clr);
    check(!busy && !start_flag, "R9 stop on clear", int'(busy), 0);
    cont_mode = 0;

    // R11 abort mid-conversion
    prev = int'(result);
    vin = 55;
    pulse(sw_start_set);
    repeat (SAMP + 5) @(negedge clk);
    pulse(sw_start_clr);
    check(!busy && !start_flag, "R11 abort busy", int'(busy), 0);
    got = 0;
    for (int i = 0; i < 30; i++) begin
      if (eoc_irq) got = 1;
      @(negedge clk);
    end
    check(!got, "R11 no eoc", int'(got), 0);
    check(int'(result) == prev, "R11 result kept", int'(result), prev);

    // R10 comp_en drop aborts
    vin = 66;
    pulse(sw_start_set);
    repeat (SAMP + 3) @(negedge clk);
    comp_en = 0;
    @(negedge clk);
    @(negedge clk);
    check(!busy && !start_flag, "R10 disable aborts", int'(busy), 0);
    check(int'(result) == prev, "R10 result kept", int'(result), prev);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule